// File: doc/BRIEF.md
# Indexed Voice Register File

This block is the host-facing register window of a multi-voice synthesis engine. The host never addresses a voice register directly. It first loads a voice-select byte and a function-select byte through two selector ports. It then moves the chosen 16-bit word through a data window that spans two adjacent byte ports. The window can be used a whole word at a time or one byte lane at a time. A byte access touches only the lane that belongs to the port it hits, and the other lane keeps its value.

The same window also reaches three kinds of state outside the voice array: an active-voice count, a one-bit run control that guards every per-voice write, and a 20-bit pointer into a small local byte memory. The host reads and writes that memory one byte at a time through a fifth port. Stores use function codes from 0x00 upwards, and loads reach the same voice registers with codes from 0x80 upwards. A function code that names nothing reads back as all ones.

Reads are combinational from registered state. Every write lands on the clock edge that samples it.

Top module: `vrf_top`

## Requirements
- R1: Each voice (the low VOICE_W bits of the voice-select byte) owns 14 independent 16-bit registers. Store function code k (0x00..0x0D) writes register k of the selected voice, and load code 0x80+k reads that same register. Voice-select bits above VOICE_W are ignored, so the selections alias.
- R2: A byte write (`bus_word`=0) to the low data port (`bus_addr`=2) replaces bits 7:0 of the target with `bus_wdata[7:0]` and leaves bits 15:8 unchanged.
- R3: A byte write to the high data port (`bus_addr`=3) replaces bits 15:8 with `bus_wdata[7:0]` and leaves bits 7:0 unchanged. A word write (`bus_word`=1) to either data port replaces all 16 bits.
- R4: A byte read returns the lane that belongs to the port, zero-extended: bits 7:0 at port 2 and bits 15:8 at port 3. A word read returns the full register.
- R5: Writes to voice registers are discarded while the run bit is 0. The run bit is `bus_wdata[0]` of a data-port write with function 0x4C, and it is 0 after reset.
- R6: Function 0x0E writes the active-voice count from `bus_wdata[7:0]`, and 0x8E reads it zero-extended. The count is 0xCD after reset and after any 0x4C write that clears the run bit.
- R7: Function 0x43 writes pointer bits 15:0 with the lane masking of R2/R3. Function 0x44 writes pointer bits 19:16 from `bus_wdata[3:0]` and keeps bits 15:0.
- R8: The memory port (`bus_addr`=4) writes `bus_wdata[7:0]` to, and reads zero-extended from, the byte at the low MEM_AW bits of the pointer.
- R9: A data-port read under a function code other than 0x80..0x8E returns 0xFFFF for both byte and word reads, as does a read of any port address above 4.
- R10: Port 0 reads back the voice-select byte and port 1 reads back the function-select byte, each zero-extended.
- R11: A write changes the read data on the first clock edge with `bus_we` high, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Port: 0 voice select, 1 function select, 2 data low, 3 data high, 4 memory byte |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access on bits 7:0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current `bus_addr` (combinational) |

## Verification
The bench builds the block with VOICE_W=3 and MEM_AW=4. With 8 voices, a voice-select value such as 0x0A lands on voice 2, so the aliasing of unused select bits can be seen at the ports. With a 16-byte memory, a pointer written through the high lane or the upper nibble still reaches a byte that is already known. Two pointer values that differ only above bit 3 reach the same byte. The bench also drives the lock and unlock order and the soft count reset through the run bit, and it checks, at a single clock edge, when a write becomes visible.

// File: rtl/vrf_pkg.sv
// Package: shared codes and the decoded write-request type of the voice register file.
// Assumes an 8-bit function select and a 16-bit data window.
package vrf_pkg;
    localparam int PTR_W = 20;

    typedef enum logic [2:0] {
        PA_VSEL = 3'd0,
        PA_FSEL = 3'd1,
        PA_DLO  = 3'd2,
        PA_DHI  = 3'd3,
        PA_MEM  = 3'd4
    } port_e;

    localparam logic [7:0] FN_VOICE_LAST = 8'h0D;
    localparam logic [7:0] FN_RD_BASE    = 8'h80;
    localparam logic [7:0] FN_RD_LAST    = 8'h8D;
    localparam logic [7:0] FN_CNT_WR     = 8'h0E;
    localparam logic [7:0] FN_CNT_RD     = 8'h8E;
    localparam logic [7:0] FN_PTR_LO     = 8'h43;
    localparam logic [7:0] FN_PTR_HI     = 8'h44;
    localparam logic [7:0] FN_CTL        = 8'h4C;
    localparam logic [7:0] CNT_INIT      = 8'hCD;

    typedef struct packed {
        logic        vsel_we;
        logic        fsel_we;
        logic        voice_we;
        logic        cnt_we;
        logic        ctl_we;
        logic        plo_we;
        logic        phi_we;
        logic        mem_we;
        logic [1:0]  lane_mask;
        logic [15:0] lane_data;
    } wr_req_t;
endpackage

// File: rtl/vrf_decode.sv
// Module: turns one host write into per-target enables plus lane mask and aligned data.
// Assumes byte data always arrives on bits 7:0 and the run bit gates only voice writes.
module vrf_decode
    import vrf_pkg::*;
(
    input  logic [2:0]  addr,
    input  logic        we,
    input  logic        word,
    input  logic [15:0] wdata,
    input  logic [7:0]  fsel,
    input  logic        run,
    output wr_req_t     req
);
    logic data_hit;

    // Purpose: classify the write by port and function code and align the lanes.
    always_comb begin
        req      = '0;
        data_hit = we && (addr == PA_DLO || addr == PA_DHI);
        if (word) begin
            req.lane_mask = 2'b11;
            req.lane_data = wdata;
        end else if (addr == PA_DHI) begin
            req.lane_mask = 2'b10;
            req.lane_data = {wdata[7:0], 8'h00};
        end else begin
            req.lane_mask = 2'b01;
            req.lane_data = {8'h00, wdata[7:0]};
        end
        req.vsel_we  = we && (addr == PA_VSEL);
        req.fsel_we  = we && (addr == PA_FSEL);
        req.mem_we   = we && (addr == PA_MEM);
        req.voice_we = data_hit && run && (fsel <= FN_VOICE_LAST);
        req.cnt_we   = data_hit && (fsel == FN_CNT_WR);
        req.ctl_we   = data_hit && (fsel == FN_CTL);
        req.plo_we   = data_hit && (fsel == FN_PTR_LO);
        req.phi_we   = data_hit && (fsel == FN_PTR_HI);
    end
endmodule

// File: rtl/vrf_voice_bank.sv
// Module: storage of NFUNC 16-bit words for each of 2**VOICE_W voices, byte-lane writable.
// Assumes a function index at or above NFUNC is never stored and reads as zero.
module vrf_voice_bank #(
    parameter int VOICE_W = 5,
    parameter int NFUNC   = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [VOICE_W-1:0] wr_voice,
    input  logic [3:0]         wr_func,
    input  logic [1:0]         wr_mask,
    input  logic [15:0]        wr_data,
    input  logic [VOICE_W-1:0] rd_voice,
    input  logic [3:0]         rd_func,
    output logic [15:0]        rd_data
);
    localparam int NV = 1 << VOICE_W;

    logic [15:0] row_rd [NV];

    for (genvar gv = 0; gv < NV; gv++) begin : g_voice
        logic [15:0] row [NFUNC];
        logic        hit;

        assign hit = wr_en && (wr_voice == VOICE_W'(gv)) && (wr_func < 4'(NFUNC));

        // Purpose: clear this voice's words on reset, else merge the enabled lanes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int f = 0; f < NFUNC; f++) row[f] <= '0;
            end else if (hit) begin
                if (wr_mask[0]) row[wr_func][7:0]  <= wr_data[7:0];
                if (wr_mask[1]) row[wr_func][15:8] <= wr_data[15:8];
            end
        end

        // Purpose: present the addressed word of this voice.
        assign row_rd[gv] = (rd_func < 4'(NFUNC)) ? row[rd_func] : 16'h0000;
    end

    // Purpose: pick the selected voice's word.
    assign rd_data = row_rd[rd_voice];
endmodule

// File: rtl/vrf_lmem.sv
// Module: 20-bit local memory pointer and a 2**MEM_AW byte memory behind it.
// Assumes MEM_AW <= 20; pointer bits above MEM_AW alias onto the same bytes.
module vrf_lmem
    import vrf_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             plo_we,
    input  logic             phi_we,
    input  logic [1:0]       lane_mask,
    input  logic [15:0]      lane_data,
    input  logic [3:0]       hi_nib,
    input  logic             mem_we,
    input  logic [7:0]       wbyte,
    output logic [PTR_W-1:0] ptr,
    output logic [7:0]       rbyte
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0]        mem [DEPTH];
    logic [MEM_AW-1:0] idx;

    assign idx = ptr[MEM_AW-1:0];

    // Purpose: update the pointer from the low-lane, high-lane and top-nibble writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            if (plo_we && lane_mask[0]) ptr[7:0]   <= lane_data[7:0];
            if (plo_we && lane_mask[1]) ptr[15:8]  <= lane_data[15:8];
            if (phi_we)                 ptr[19:16] <= hi_nib;
        end
    end

    // Purpose: clear the byte memory on reset, else store a poked byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (mem_we) begin
            mem[idx] <= wbyte;
        end
    end

    // Purpose: peek the byte under the pointer.
    assign rbyte = mem[idx];
endmodule

// File: rtl/vrf_top.sv
// Module: indexed voice register file; selectors, data window, count, run bit and memory port.
// Assumes reads have no side effects, so the read data is a pure function of state and bus_addr.
module vrf_top
    import vrf_pkg::*;
#(
    parameter int VOICE_W = 5,
    parameter int MEM_AW  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_we,
    input  logic        bus_word,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata
);
    localparam int NFUNC = int'(FN_VOICE_LAST) + 1;

    logic [7:0]       vsel;
    logic [7:0]       fsel;
    logic [7:0]       cnt;
    logic             ctl_run;
    wr_req_t          req;
    logic [15:0]      bank_rd;
    logic [PTR_W-1:0] ptr;
    logic [7:0]       mem_rd;
    logic             voice_rd;

    vrf_decode u_dec (
        .addr  (bus_addr),
        .we    (bus_we),
        .word  (bus_word),
        .wdata (bus_wdata),
        .fsel  (fsel),
        .run   (ctl_run),
        .req   (req)
    );

    vrf_voice_bank #(.VOICE_W(VOICE_W), .NFUNC(NFUNC)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (req.voice_we),
        .wr_voice (vsel[VOICE_W-1:0]),
        .wr_func  (fsel[3:0]),
        .wr_mask  (req.lane_mask),
        .wr_data  (req.lane_data),
        .rd_voice (vsel[VOICE_W-1:0]),
        .rd_func  (fsel[3:0]),
        .rd_data  (bank_rd)
    );

    vrf_lmem #(.MEM_AW(MEM_AW)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .plo_we    (req.plo_we),
        .phi_we    (req.phi_we),
        .lane_mask (req.lane_mask),
        .lane_data (req.lane_data),
        .hi_nib    (bus_wdata[3:0]),
        .mem_we    (req.mem_we),
        .wbyte     (bus_wdata[7:0]),
        .ptr       (ptr),
        .rbyte     (mem_rd)
    );

    // Purpose: hold the selectors, the active-voice count and the run bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsel    <= 8'h00;
            fsel    <= 8'h00;
            cnt     <= CNT_INIT;
            ctl_run <= 1'b0;
        end else begin
            if (req.vsel_we) vsel <= bus_wdata[7:0];
            if (req.fsel_we) fsel <= bus_wdata[7:0];
            if (req.cnt_we)  cnt  <= bus_wdata[7:0];
            if (req.ctl_we) begin
                ctl_run <= bus_wdata[0];
                if (!bus_wdata[0]) cnt <= CNT_INIT;
            end
        end
    end

    assign voice_rd = (fsel >= FN_RD_BASE) && (fsel <= FN_RD_LAST);

    // Purpose: select read data by port, function code and access width.
    always_comb begin
        bus_rdata = 16'hFFFF;
        case (bus_addr)
            PA_VSEL: bus_rdata = {8'h00, vsel};
            PA_FSEL: bus_rdata = {8'h00, fsel};
            PA_DLO, PA_DHI: begin
                if (voice_rd) begin
                    if (bus_word)                bus_rdata = bank_rd;
                    else if (bus_addr == PA_DHI) bus_rdata = {8'h00, bank_rd[15:8]};
                    else                         bus_rdata = {8'h00, bank_rd[7:0]};
                end else if (fsel == FN_CNT_RD) begin
                    bus_rdata = {8'h00, cnt};
                end
            end
            PA_MEM:  bus_rdata = {8'h00, mem_rd};
            default: bus_rdata = 16'hFFFF;
        endcase
    end
endmodule

// File: rtl/vrf_chk.sv
// Module: checker bound to vrf_top; watches the bus and selected internal registers.
// Assumes it is attached by the bind below and sees the top's default-named signals.
module vrf_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  bus_addr,
    input logic        bus_we,
    input logic        bus_word,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic [7:0]  vsel,
    input logic [7:0]  fsel,
    input logic [7:0]  cnt,
    input logic        ctl_run,
    input logic        voice_we,
    input logic [19:0] ptr
);
    logic data_port;
    assign data_port = (bus_addr == 3'd2) || (bus_addr == 3'd3);

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 3'd0) |=> (vsel == $past(bus_wdata[7:0]))); // R10

    AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_run) |-> (!voice_we)); // R5

    AST_SOFT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && data_port && fsel == 8'h4C && !bus_wdata[0]) |=> (cnt == 8'hCD)); // R6

    AST_PTR_TOP_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && data_port && fsel == 8'h44)
        |=> (ptr[19:16] == $past(bus_wdata[3:0]) && ptr[15:0] == $past(ptr[15:0]))); // R7

    AST_PTR_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_word && bus_addr == 3'd2 && fsel == 8'h43)
        |=> (ptr[19:8] == $past(ptr[19:8]))); // R7

    AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (data_port && !(fsel >= 8'h80 && fsel <= 8'h8E)) |-> (bus_rdata == 16'hFFFF)); // R9
endmodule

bind vrf_top vrf_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_word  (bus_word),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .vsel      (vsel),
    .fsel      (fsel),
    .cnt       (cnt),
    .ctl_run   (ctl_run),
    .voice_we  (req.voice_we),
    .ptr       (ptr)
);

// File: tb/sim_vrf_top.sv
// Bench: vector table walk plus directed reset, lock and timing checks for vrf_top.
module sim_vrf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_we = 1'b0;
    logic        bus_word = 1'b0;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vrf_top #(.VOICE_W(3), .MEM_AW(4)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    typedef struct packed {
        logic [2:0]  a;
        logic        we;
        logic        wd;
        logic [15:0] d;
        logic [3:0]  rq;
    } vec_t;

    // a, we, word, data (write) or expected (read), requirement number
    localparam vec_t VECS [64] = '{
        '{3'd1,1'b1,1'b0,16'h004C,4'd5},  // R5 unlock
        '{3'd2,1'b1,1'b0,16'h0001,4'd5},
        '{3'd0,1'b1,1'b0,16'h0002,4'd1},  // R1 word store/load
        '{3'd1,1'b1,1'b0,16'h0003,4'd1},
        '{3'd2,1'b1,1'b1,16'hA55A,4'd1},
        '{3'd1,1'b1,1'b0,16'h0083,4'd1},
        '{3'd2,1'b0,1'b1,16'hA55A,4'd1},
        '{3'd1,1'b1,1'b0,16'h0003,4'd2},  // R2 low lane
        '{3'd2,1'b1,1'b0,16'h0011,4'd2},
        '{3'd1,1'b1,1'b0,16'h0083,4'd2},
        '{3'd2,1'b0,1'b1,16'hA511,4'd2},
        '{3'd1,1'b1,1'b0,16'h0003,4'd3},  // R3 high lane
        '{3'd3,1'b1,1'b0,16'h0022,4'd3},
        '{3'd1,1'b1,1'b0,16'h0083,4'd3},
        '{3'd2,1'b0,1'b1,16'h2211,4'd3},
        '{3'd3,1'b0,1'b0,16'h0022,4'd4},  // R4 byte reads
        '{3'd2,1'b0,1'b0,16'h0011,4'd4},
        '{3'd3,1'b0,1'b1,16'h2211,4'd4},
        '{3'd0,1'b1,1'b0,16'h0005,4'd1},  // R1 other voice independent
        '{3'd1,1'b1,1'b0,16'h0003,4'd1},
        '{3'd2,1'b1,1'b1,16'h1234,4'd1},
        '{3'd0,1'b1,1'b0,16'h0002,4'd1},
        '{3'd1,1'b1,1'b0,16'h0083,4'd1},
        '{3'd2,1'b0,1'b1,16'h2211,4'd1},
        '{3'd0,1'b1,1'b0,16'h000A,4'd1},  // R1 select alias 0x0A -> voice 2
        '{3'd2,1'b0,1'b1,16'h2211,4'd1},
        '{3'd0,1'b0,1'b0,16'h000A,4'd10}, // R10 selector read-back
        '{3'd1,1'b0,1'b0,16'h0083,4'd10},
        '{3'd1,1'b1,1'b0,16'h008D,4'd1},  // R1 last function untouched
        '{3'd2,1'b0,1'b1,16'h0000,4'd1},
        '{3'd1,1'b1,1'b0,16'h0020,4'd9},  // R9 unmapped
        '{3'd2,1'b0,1'b1,16'hFFFF,4'd9},
        '{3'd3,1'b0,1'b0,16'hFFFF,4'd9},
        '{3'd5,1'b0,1'b0,16'hFFFF,4'd9},
        '{3'd1,1'b1,1'b0,16'h000E,4'd6},  // R6 count write/read
        '{3'd2,1'b1,1'b0,16'h001C,4'd6},
        '{3'd1,1'b1,1'b0,16'h008E,4'd6},
        '{3'd2,1'b0,1'b0,16'h001C,4'd6},
        '{3'd1,1'b1,1'b0,16'h0043,4'd7},  // R7 pointer low
        '{3'd2,1'b1,1'b1,16'h0005,4'd7},
        '{3'd4,1'b1,1'b0,16'h0077,4'd8},  // R8 poke
        '{3'd3,1'b1,1'b0,16'h0099,4'd7},
        '{3'd4,1'b0,1'b0,16'h0077,4'd7},
        '{3'd4,1'b1,1'b0,16'h0055,4'd8},
        '{3'd1,1'b1,1'b0,16'h0044,4'd7},  // R7 pointer top nibble
        '{3'd2,1'b1,1'b1,16'hFFFF,4'd7},
        '{3'd4,1'b0,1'b0,16'h0055,4'd7},
        '{3'd1,1'b1,1'b0,16'h0043,4'd8},  // R8 alias on low MEM_AW bits
        '{3'd2,1'b1,1'b1,16'h0025,4'd8},
        '{3'd4,1'b0,1'b0,16'h0055,4'd8},
        '{3'd1,1'b1,1'b0,16'h004C,4'd6},  // R6 soft count reset
        '{3'd2,1'b1,1'b0,16'h0000,4'd6},
        '{3'd1,1'b1,1'b0,16'h008E,4'd6},
        '{3'd2,1'b0,1'b0,16'h00CD,4'd6},
        '{3'd0,1'b1,1'b0,16'h0002,4'd5},  // R5 locked write dropped
        '{3'd1,1'b1,1'b0,16'h0003,4'd5},
        '{3'd2,1'b1,1'b1,16'hBEEF,4'd5},
        '{3'd1,1'b1,1'b0,16'h0083,4'd5},
        '{3'd2,1'b0,1'b1,16'h2211,4'd5},
        '{3'd1,1'b1,1'b0,16'h004C,4'd5},  // R5 unlock through high port
        '{3'd3,1'b1,1'b0,16'h0001,4'd5},
        '{3'd1,1'b1,1'b0,16'h0003,4'd5},
        '{3'd2,1'b1,1'b1,16'hBEEF,4'd5},
        '{3'd1,1'b1,1'b0,16'h0083,4'd5}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %04h expected %04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic w, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_word = w; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic w, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_word = w; bus_we = 1'b0;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        rd(3'd0, 1'b0, 16'h0000, "R10 reset voice select");
        wr(3'd1, 1'b0, 16'h008E);
        rd(3'd2, 1'b0, 16'h00CD, "R6 reset count");
        rd(3'd4, 1'b0, 16'h0000, "R8 reset memory byte");
        // Writes blocked right after reset (run bit 0)
        wr(3'd1, 1'b0, 16'h0000);
        wr(3'd2, 1'b1, 16'h1111);
        wr(3'd1, 1'b0, 16'h0080);
        rd(3'd2, 1'b1, 16'h0000, "R5 locked after reset");

        for (int i = 0; i < 64; i++) begin
            if (VECS[i].we) wr(VECS[i].a, VECS[i].wd, VECS[i].d);
            else rd(VECS[i].a, VECS[i].wd, VECS[i].d, $sformatf("R%0d vector %0d", VECS[i].rq, i));
        end
        rd(3'd2, 1'b1, 16'hBEEF, "R5 write after unlock");

        // R11: a write is visible only after the sampling edge
        @(negedge clk);
        bus_addr = 3'd0; bus_word = 1'b0; bus_wdata = 16'h001F; bus_we = 1'b1;
        #1;
        check("R11 before edge", bus_rdata, 16'h0002);
        @(posedge clk);
        #1;
        check("R11 after edge", bus_rdata, 16'h001F);
        @(negedge clk);
        bus_we = 1'b0;
        // R2 edge: a byte write to the low lane of a fresh voice register
        wr(3'd1, 1'b0, 16'h0007);
        wr(3'd2, 1'b0, 16'h00AB);
        wr(3'd1, 1'b0, 16'h0087);
        rd(3'd2, 1'b1, 16'h00AB, "R2 fresh register low lane");
        finish_run();
    end
endmodule